// File: doc/BRIEF.md
# Binary to Radix-1000 Digit Converter

This block takes a 14-bit unsigned binary integer and splits it into two radix-1000 digits: a high digit from 0 to 9 and a low digit from 0 to 999, both in binary. The block has no divider. It cuts the input at bit 10, so the value equals `hi_part*1024 + lo_part`. Since 1024 is 1000 plus 24, the value also equals `hi_part*1000 + (hi_part*24 + lo_part)`. The bracketed sum gives the first estimate of the low digit, and `hi_part` gives the first estimate of the high digit. The sum is never larger than 1215 for a legal input. One compare-and-subtract of 1000, with a matching increment of the high digit, therefore always gives the final pair.

An arithmetic unit that works in radix-1000 uses the block to turn binary intermediate results back into digits. The input is qualified by a valid strobe. The result comes out of one register stage with a matching valid bit. An input larger than 9999 is not a legal operand: the block raises an error flag and returns zero digits.

Top module: `kilo_digit_conv`

## Requirements
- R1: For any input value v in 0..9999 presented with `in_valid` high, the result one clock later is `out_hi` = v / 1000 and `out_lo` = v mod 1000.
- R2: `out_valid` is high in the cycle after an edge that sampled `in_valid` high, and low in the cycle after an edge that sampled `in_valid` low.
- R3: When the 10 low input bits plus 24 times the 4 high input bits reach 1000 or more (for example 1000, 1023, 2000), the result shows the high digit raised by one and 1000 taken from the low digit. At 999 or below (for example 999, 1999, 9999) the estimate is passed through unchanged.
- R4: Whenever `out_valid` is high, `out_lo` is below 1000 and `out_hi` is at most 9.
- R5: An input value above 9999 presented with `in_valid` high gives `out_err` = 1 with `out_hi` = 0 and `out_lo` = 0 one clock later.
- R6: A legal input value gives `out_err` = 0 alongside its result.
- R7: An edge with `in_valid` low leaves `out_hi`, `out_lo` and `out_err` at their previous values, whatever `in_value` holds.
- R8: Driving `rst_n` low clears `out_valid`, `out_err`, `out_hi` and `out_lo` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_value | input | 14 | Unsigned binary operand |
| out_valid | output | 1 | Registered result is present |
| out_hi | output | 4 | High radix-1000 digit (0..9) |
| out_lo | output | 10 | Low radix-1000 digit (0..999) |
| out_err | output | 1 | Operand was above 9999 |

## Verification
A table of hand-picked values sits on both sides of the correction threshold. The values 999, 1999 and 9999 produce an intermediate sum just below 1000. The values 1000, 1023 and 2000 land on or just past it. A missing increment or a wrong compare therefore shows up as an off-by-one digit. Every legal value from 0 to 9999 is then streamed back to back and compared with division and remainder by 1000. This catches any single wrong bit in the shift-add path. Out-of-range samples, including 10000 and the all-ones input, separate the error path from the legal one. A held-input test and a mid-run asynchronous reset show that the enable and the reset act as required.

// File: rtl/kd_pkg.sv
package kd_pkg;
  localparam int unsigned KD_IN_W  = 14;
  localparam int unsigned KD_SPLIT = 10;
  localparam int unsigned KD_RADIX = 1000;
  localparam int unsigned KD_MAXV  = 9999;
  localparam int unsigned KD_HI_W  = $clog2(KD_MAXV / KD_RADIX + 1);
  localparam int unsigned KD_LO_W  = $clog2(KD_RADIX);

  typedef struct packed {
    logic               err;
    logic [KD_HI_W-1:0] hi;
    logic [KD_LO_W-1:0] lo;
  } kd_result_t;
endpackage

// File: rtl/kd_estimate.sv
module kd_estimate #(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned SPLIT = 10,
  parameter int unsigned RADIX = 1000,
  localparam int unsigned TOP_W = IN_W - SPLIT,
  localparam int unsigned C_W   = SPLIT + 1,
  localparam int unsigned DELTA = (1 << SPLIT) - RADIX
) (
  input  logic [IN_W-1:0]  value_i,
  output logic [TOP_W-1:0] top_o,
  output logic [C_W-1:0]   sum_o
);
  logic [TOP_W-1:0] top;
  logic [SPLIT-1:0] bot;
  logic [C_W-1:0]   scaled;

  assign top = value_i[IN_W-1:SPLIT];
  assign bot = value_i[SPLIT-1:0];

  generate
    if (DELTA == 24 && C_W >= TOP_W + 4) begin : g_shift_add
      always_comb begin
        scaled = C_W'({top, 4'b0000}) + C_W'({top, 3'b000});
      end
    end else begin : g_mult
      always_comb begin
        scaled = C_W'(top) * C_W'(DELTA);
      end
    end
  endgenerate

  always_comb begin
    top_o = top;
    sum_o = scaled + C_W'(bot);
  end
endmodule

// File: rtl/kd_correct.sv
module kd_correct #(
  parameter int unsigned TOP_W = 4,
  parameter int unsigned C_W   = 11,
  parameter int unsigned RADIX = 1000,
  parameter int unsigned HI_W  = 4,
  parameter int unsigned LO_W  = 10
) (
  input  logic [TOP_W-1:0] top_i,
  input  logic [C_W-1:0]   sum_i,
  output logic [HI_W-1:0]  hi_o,
  output logic [LO_W-1:0]  lo_o
);
  logic           over;
  logic [C_W-1:0] diff;
  logic [C_W-1:0] pick;

  always_comb begin
    over = (sum_i >= C_W'(RADIX));
    diff = sum_i - C_W'(RADIX);
    pick = over ? diff : sum_i;
    lo_o = pick[LO_W-1:0];
    hi_o = HI_W'(top_i) + HI_W'(over);
  end
endmodule

// File: rtl/kd_range.sv
module kd_range #(
  parameter int unsigned IN_W = 14,
  parameter int unsigned MAXV = 9999
) (
  input  logic [IN_W-1:0] value_i,
  output logic            err_o
);
  always_comb begin
    err_o = (value_i > IN_W'(MAXV));
  end
endmodule

// File: rtl/kilo_digit_conv.sv
module kilo_digit_conv
  import kd_pkg::*;
#(
  parameter int unsigned IN_W  = KD_IN_W,
  parameter int unsigned SPLIT = KD_SPLIT,
  parameter int unsigned RADIX = KD_RADIX,
  parameter int unsigned MAXV  = KD_MAXV,
  localparam int unsigned HI_W  = KD_HI_W,
  localparam int unsigned LO_W  = KD_LO_W,
  localparam int unsigned TOP_W = IN_W - SPLIT,
  localparam int unsigned C_W   = SPLIT + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_value,
  output logic            out_valid,
  output logic [HI_W-1:0] out_hi,
  output logic [LO_W-1:0] out_lo,
  output logic            out_err
);
  logic [TOP_W-1:0] est_top;
  logic [C_W-1:0]   est_sum;
  logic [HI_W-1:0]  fix_hi;
  logic [LO_W-1:0]  fix_lo;
  logic             bad;

  kd_result_t res_d, res_q;
  logic       vld_d, vld_q;
  logic       load_en;

  kd_estimate #(.IN_W(IN_W), .SPLIT(SPLIT), .RADIX(RADIX)) u_est (
    .value_i (in_value),
    .top_o   (est_top),
    .sum_o   (est_sum)
  );

  kd_correct #(.TOP_W(TOP_W), .C_W(C_W), .RADIX(RADIX),
               .HI_W(HI_W), .LO_W(LO_W)) u_fix (
    .top_i (est_top),
    .sum_i (est_sum),
    .hi_o  (fix_hi),
    .lo_o  (fix_lo)
  );

  kd_range #(.IN_W(IN_W), .MAXV(MAXV)) u_rng (
    .value_i (in_value),
    .err_o   (bad)
  );

  // next state
  always_comb begin
    load_en = in_valid;
    vld_d   = in_valid;
    res_d   = res_q;
    if (load_en) begin
      res_d.err = bad;
      res_d.hi  = bad ? '0 : fix_hi;
      res_d.lo  = bad ? '0 : fix_lo;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign out_hi    = res_q.hi;
  assign out_lo    = res_q.lo;
  assign out_err   = res_q.err;

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_digit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lo < LO_W'(RADIX)) && (out_hi <= HI_W'(MAXV / RADIX)));
  a_r5_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_hi == '0) && (out_lo == '0));
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_value > IN_W'(MAXV))) |=> out_err);
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_value <= IN_W'(MAXV))) |=> !out_err);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_hi) && $stable(out_lo) && $stable(out_err)));
endmodule

// File: tb/kilo_digit_conv_bench.sv
`timescale 1ns/1ps
module kilo_digit_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [13:0] in_value;
  logic        out_valid;
  logic [3:0]  out_hi;
  logic [9:0]  out_lo;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kilo_digit_conv u_kilo_digit_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo), .out_err(out_err)
  );

  // {value, hi, lo, err}
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {14'd0,     4'd0, 10'd0,   1'b0},
    {14'd999,   4'd0, 10'd999, 1'b0},
    {14'd1000,  4'd1, 10'd0,   1'b0},
    {14'd1023,  4'd1, 10'd23,  1'b0},
    {14'd1024,  4'd1, 10'd24,  1'b0},
    {14'd1999,  4'd1, 10'd999, 1'b0},
    {14'd2000,  4'd2, 10'd0,   1'b0},
    {14'd5000,  4'd5, 10'd0,   1'b0},
    {14'd9216,  4'd9, 10'd216, 1'b0},
    {14'd9999,  4'd9, 10'd999, 1'b0},
    {14'd10000, 4'd0, 10'd0,   1'b1},
    {14'd16383, 4'd0, 10'd0,   1'b1}
  };

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [13:0] v);
    in_valid = 1'b1;
    in_value = v;
    @(negedge clk);
  endtask

  initial begin
    in_valid = 1'b0;
    in_value = '0;
    rst_n    = 1'b0;
    #1;
    check("R8 reset valid", 15'(out_valid), 15'd0);
    check("R8 reset err",   15'(out_err),   15'd0);
    check("R8 reset digits", {1'b0, out_hi, out_lo}, 15'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle valid", 15'(out_valid), 15'd0);

    // R1 R3 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][28:15]);
      check("R2 valid", 15'(out_valid), 15'd1);
      check("R1 R3 R5 hi", 15'(out_hi), 15'(VEC[i][14:11]));
      check("R1 R3 R5 lo", 15'(out_lo), 15'(VEC[i][10:1]));
      check("R5 R6 err", 15'(out_err), 15'(VEC[i][0]));
    end

    // R1 R4 full sweep, back to back
    for (int v = 0; v <= 9999; v++) begin
      push(14'(v));
      check("R1 hi", 15'(out_hi), 15'(v / 1000));
      check("R1 lo", 15'(out_lo), 15'(v % 1000));
      check("R6 err", 15'(out_err), 15'd0);
    end

    // R5 out-of-range sample
    for (int v = 10000; v < 16384; v += 397) begin
      push(14'(v));
      check("R5 err", 15'(out_err), 15'd1);
      check("R5 zero digits", {1'b0, out_hi, out_lo}, 15'd0);
    end

    // R7 hold with changing input while invalid
    push(14'd1234);
    in_valid = 1'b0;
    in_value = 14'd12000;
    @(negedge clk);
    check("R2 valid low", 15'(out_valid), 15'd0);
    check("R7 hold hi", 15'(out_hi), 15'd1);
    check("R7 hold lo", 15'(out_lo), 15'd234);
    check("R7 hold err", 15'(out_err), 15'd0);
    in_value = 14'd7777;
    @(negedge clk);
    check("R7 hold lo again", 15'(out_lo), 15'd234);

    // R8 asynchronous reset mid-run
    push(14'd10001);
    push(14'd8765);
    #1 rst_n = 1'b0;
    #0.5;
    check("R8 async valid", 15'(out_valid), 15'd0);
    check("R8 async digits", {1'b0, out_hi, out_lo}, 15'd0);
    check("R8 async err", 15'(out_err), 15'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", 15'(out_valid), 15'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule